// File: doc/BRIEF.md
# Second-Order Parity-Matched Noise Sample Generator

This block is one stage of a successive requantizer chain. On every enabled cycle it emits a small signed noise sample whose parity equals the parity of the stage's data input. Adding that sample to the data value makes the sum even, so the next stage can halve it exactly. The sample is the second difference of a bounded internal state sequence. Its running sum and its double running sum therefore both stay bounded, and the noise is second-order highpass shaped.

The internal state takes one of five values, -2 to +2. Each new state is drawn from a fixed lookup keyed by three things: the previous state, a parity bit, and a 4-bit uniform random code. The parity bit comes from the input's low bit and the two most recent states. The lookup encodes two probability tables, one for even parity and one for odd parity. The tables are chosen so that the running sum of the noise keeps its immunity to spurious tones. The random code comes from an on-block shift register that advances four bits per enabled cycle. Clearing the enable freezes the whole stage.

Top module: `pns_stage`

## Requirements
- R1: A synchronous active-high reset sets the state output, the first-difference output and the sample output to 0. After reset, the two previous states are taken as 0.
- R2: After each enabled cycle, the new sample s_out has the same parity as the x_lsb input of that cycle.
- R3: Let o be the XOR of x_lsb and the low bits of the two previous states. The new state plus the previous state has parity o, and the new state is a transition that has non-zero probability in the table for o.
- R4: After each enabled cycle, t_out equals the new state minus the previous state. s_out equals the new state, minus twice the previous state, plus the state before that.
- R5: u_out stays within -2..+2, t_out within -4..+4 and s_out within -8..+8.
- R6: While en is low, u_out, t_out and s_out hold their values.
- R7: The rate of each next state follows the table, in sixteenths. From +1 with even parity: +1 at 10/16 and -1 at 6/16. From 0 with even parity: +2 at 2/16, 0 at 12/16 and -2 at 2/16. From +1 with odd parity: +2 at 3/16, 0 at 12/16 and -2 at 1/16. The other rows are: even parity +2→{+2:4, 0:12}, -1→{+1:6, -1:10}, -2→{0:12, -2:4}; odd parity +2→{+1:12, -1:4}, 0→{+1:8, -1:8}, -1→{+2:1, 0:12, -2:3}, -2→{+1:4, -1:12}.
- R8: From reset, the running sum of s_out equals t_out, and the running sum of t_out equals u_out. The double running sum of the noise is therefore the bounded state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the stage by one sample |
| x_lsb | input | 1 | Low bit of the stage's data input |
| s_out | output | 5 | Noise sample, two's complement |
| t_out | output | 4 | First difference of the state, two's complement |
| u_out | output | 3 | Current state, two's complement |

## Verification
A wrong state register corrupts all three outputs on the next enabled edge. It breaks the agreement between the summed samples and t_out, and between the summed differences and u_out. It can also produce a step that the active table forbids. A parity slip shows at once as an odd s_out against an even x_lsb. A wrong table threshold leaves every single step legal and appears only in the transition rates, after some thousands of samples.

// File: rtl/pns_pkg.sv
package pns_pkg;
  localparam int U_W    = 3;
  localparam int T_W    = 4;
  localparam int S_W    = 5;
  localparam int CODE_W = 4;

  typedef logic signed [U_W-1:0] state_t;

  typedef struct packed {
    state_t          tgt0;
    state_t          tgt1;
    state_t          tgt2;
    logic [CODE_W:0] cnt0;
    logic [CODE_W:0] cnt1;
  } row_t;

  // Targets are in descending order of value. Code counts are in sixteenths.
  function automatic row_t row_of(input state_t prev, input logic par);
    row_t r;
    r = '{tgt0: 3'sd0, tgt1: 3'sd0, tgt2: 3'sd0, cnt0: 5'd16, cnt1: 5'd0};
    if (!par) begin
      case (prev)
        3'sd2:  r = '{tgt0: 3'sd2,  tgt1: 3'sd0,  tgt2: 3'sd0,  cnt0: 5'd4,  cnt1: 5'd12};
        3'sd1:  r = '{tgt0: 3'sd1,  tgt1: -3'sd1, tgt2: -3'sd1, cnt0: 5'd10, cnt1: 5'd6};
        3'sd0:  r = '{tgt0: 3'sd2,  tgt1: 3'sd0,  tgt2: -3'sd2, cnt0: 5'd2,  cnt1: 5'd12};
        -3'sd1: r = '{tgt0: 3'sd1,  tgt1: -3'sd1, tgt2: -3'sd1, cnt0: 5'd6,  cnt1: 5'd10};
        -3'sd2: r = '{tgt0: 3'sd0,  tgt1: -3'sd2, tgt2: -3'sd2, cnt0: 5'd12, cnt1: 5'd4};
        default: ;
      endcase
    end else begin
      case (prev)
        3'sd2:  r = '{tgt0: 3'sd1,  tgt1: -3'sd1, tgt2: -3'sd1, cnt0: 5'd12, cnt1: 5'd4};
        3'sd1:  r = '{tgt0: 3'sd2,  tgt1: 3'sd0,  tgt2: -3'sd2, cnt0: 5'd3,  cnt1: 5'd12};
        3'sd0:  r = '{tgt0: 3'sd1,  tgt1: -3'sd1, tgt2: -3'sd1, cnt0: 5'd8,  cnt1: 5'd8};
        -3'sd1: r = '{tgt0: 3'sd2,  tgt1: 3'sd0,  tgt2: -3'sd2, cnt0: 5'd1,  cnt1: 5'd12};
        -3'sd2: r = '{tgt0: 3'sd1,  tgt1: -3'sd1, tgt2: -3'sd1, cnt0: 5'd4,  cnt1: 5'd12};
        default: ;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/pns_lfsr.sv
module pns_lfsr #(
  parameter int          W     = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1,
  parameter int          OUT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [OUT_W-1:0] bits
);
  logic [W-1:0] st_q;
  logic [W-1:0] st_n;

  // Galois shift register, stepped OUT_W times per advance.
  always_comb begin
    st_n = st_q;
    bits = '0;
    for (int i = 0; i < OUT_W; i++) begin
      bits[i] = st_n[0];
      st_n    = (st_n >> 1) ^ (st_n[0] ? TAPS : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      st_q <= SEED;
    else if (adv) st_q <= st_n;
  end

  // R7: the rates depend on a register that never locks up at zero.
  a_r7_lfsr_alive: assert property (@(posedge clk) disable iff (rst) st_q != '0);
endmodule

// File: rtl/pns_next_state.sv
module pns_next_state
  import pns_pkg::*;
(
  input  state_t              prev,
  input  logic                par,
  input  logic [CODE_W-1:0]   code,
  output state_t              nxt
);
  row_t            row;
  logic [CODE_W:0] c;
  logic [CODE_W:0] edge1;

  always_comb begin
    row   = row_of(prev, par);
    c     = {1'b0, code};
    edge1 = row.cnt0 + row.cnt1;
    if (!par && prev == 3'sd0) begin
      // Fixed layout for this row: codes 8,9 go to -2, codes 10,11 go to +2.
      if (c == 5'd8 || c == 5'd9)        nxt = -3'sd2;
      else if (c == 5'd10 || c == 5'd11) nxt = 3'sd2;
      else                               nxt = 3'sd0;
    end else if (c < row.cnt0) begin
      nxt = row.tgt0;
    end else if (c < edge1) begin
      nxt = row.tgt1;
    end else begin
      nxt = row.tgt2;
    end
  end
endmodule

// File: rtl/pns_stage.sv
module pns_stage
  import pns_pkg::*;
#(
  parameter int           LFSR_W    = 16,
  parameter logic [15:0]  LFSR_TAPS = 16'hB400,
  parameter logic [15:0]  LFSR_SEED = 16'hACE1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic                  x_lsb,
  output logic signed [S_W-1:0] s_out,
  output logic signed [T_W-1:0] t_out,
  output logic signed [U_W-1:0] u_out
);
  logic [CODE_W-1:0] rnd;
  logic [CODE_W-1:0] code;
  logic              par;
  state_t            u1_q, u2_q, u_new;
  logic signed [S_W-1:0] s_n;
  logic signed [T_W-1:0] t_n;

  pns_lfsr #(
    .W(LFSR_W), .TAPS(LFSR_TAPS[LFSR_W-1:0]),
    .SEED(LFSR_SEED[LFSR_W-1:0]), .OUT_W(CODE_W)
  ) u_rng (
    .clk(clk), .rst(rst), .adv(en), .bits(rnd)
  );

  // The random draw is two's complement -8..7; the code is offset by 8.
  assign code = {~rnd[CODE_W-1], rnd[CODE_W-2:0]};

  // Parity of x + u[n-1] - u[n-2].
  assign par = x_lsb ^ u1_q[0] ^ u2_q[0];

  pns_next_state u_tab (
    .prev(u1_q), .par(par), .code(code), .nxt(u_new)
  );

  always_comb begin
    s_n = S_W'(u_new) - (S_W'(u1_q) <<< 1) + S_W'(u2_q);
    t_n = T_W'(u_new) - T_W'(u1_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      u1_q  <= '0;
      u2_q  <= '0;
      s_out <= '0;
      t_out <= '0;
    end else if (en) begin
      u2_q  <= u1_q;
      u1_q  <= u_new;
      s_out <= s_n;
      t_out <= t_n;
    end
  end

  assign u_out = u1_q;

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(s_out) && $stable(t_out) && $stable(u_out)));
  a_r5_state_range: assert property (@(posedge clk) disable iff (rst)
    (u_out >= -3'sd2) && (u_out <= 3'sd2));
  a_r3_step_parity: assert property (@(posedge clk) disable iff (rst)
    en |=> ((u_out[0] ^ $past(u_out[0])) == $past(par)));
  a_r2_sample_parity: assert property (@(posedge clk) disable iff (rst)
    en |=> (s_out[0] == $past(x_lsb)));
  a_r4_first_diff: assert property (@(posedge clk) disable iff (rst)
    en |=> (t_out == T_W'(u_out) - T_W'($past(u_out))));
endmodule

// File: tb/sim_pns_stage.sv
module sim_pns_stage;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic x_lsb = 1'b0;
  logic signed [4:0] s_out;
  logic signed [3:0] t_out;
  logic signed [2:0] u_out;

  int checks = 0;
  int failures = 0;
  int p1, p2, acc_s, acc_t;
  int cnt [2][5][5];
  bit done = 1'b0;

  always #4 clk = ~clk;

  pns_stage u0 (
    .clk(clk), .rst(rst), .en(en), .x_lsb(x_lsb),
    .s_out(s_out), .t_out(t_out), .u_out(u_out)
  );

  // Table probabilities in sixteenths, from the requirements (R7).
  function automatic int prob16(input int o, input int prev, input int nx);
    if (o == 0) begin
      case (prev)
        2:  return (nx == 2) ? 4 : (nx == 0) ? 12 : 0;
        1:  return (nx == 1) ? 10 : (nx == -1) ? 6 : 0;
        0:  return (nx == 2 || nx == -2) ? 2 : (nx == 0) ? 12 : 0;
        -1: return (nx == 1) ? 6 : (nx == -1) ? 10 : 0;
        -2: return (nx == 0) ? 12 : (nx == -2) ? 4 : 0;
        default: return 0;
      endcase
    end
    case (prev)
      2:  return (nx == 1) ? 12 : (nx == -1) ? 4 : 0;
      1:  return (nx == 2) ? 3 : (nx == 0) ? 12 : (nx == -2) ? 1 : 0;
      0:  return (nx == 1 || nx == -1) ? 8 : 0;
      -1: return (nx == 2) ? 1 : (nx == 0) ? 12 : (nx == -2) ? 3 : 0;
      -2: return (nx == 1) ? 4 : (nx == -1) ? 12 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; en = 1'b0;
    @(posedge clk); @(posedge clk); #2;
    @(negedge clk); rst = 1'b0;
    #1;
    check(s_out == 0, "R1 s_out", s_out, 0);
    check(t_out == 0, "R1 t_out", t_out, 0);
    check(u_out == 0, "R1 u_out", u_out, 0);
    p1 = 0; p2 = 0; acc_s = 0; acc_t = 0;
  endtask

  task automatic step(input bit e, input bit x);
    int o, u, s, t, os, ot, ou;
    @(negedge clk);
    os = s_out; ot = t_out; ou = u_out;
    en = e; x_lsb = x;
    o = (x + p1 - p2) & 1;
    @(posedge clk); #2;
    u = u_out; s = s_out; t = t_out;
    if (!e) begin
      check(s == os && t == ot && u == ou, "R6 hold", s, os);
      return;
    end
    check((s & 1) == x, "R2 parity", s & 1, x);
    check(((u + p1) & 1) == o, "R3 step parity", (u + p1) & 1, o);
    check(prob16(o, p1, u) > 0, "R3 legal step", u, p1);
    check(t == u - p1, "R4 t", t, u - p1);
    check(s == u - 2 * p1 + p2, "R4 s", s, u - 2 * p1 + p2);
    check(u >= -2 && u <= 2 && t >= -4 && t <= 4 && s >= -8 && s <= 8,
          "R5 range", s, 0);
    acc_s += s; acc_t += t;
    check(acc_s == t, "R8 sum of s", t, acc_s);
    check(acc_t == u, "R8 sum of t", u, acc_t);
    if (p1 >= -2 && p1 <= 2 && u >= -2 && u <= 2) cnt[o][p1 + 2][u + 2]++;
    p2 = p1; p1 = u;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    // Directed: constant even input, constant odd input, alternating.
    for (int i = 0; i < 200; i++) step(1'b1, 1'b0);
    for (int i = 0; i < 200; i++) step(1'b1, 1'b1);
    for (int i = 0; i < 200; i++) step(1'b1, i[0]);
    // Directed: a stretch with enable low (R6).
    for (int i = 0; i < 20; i++) step(1'b0, i[1]);
    // R1: a reset in the middle of the run.
    do_reset();
    // Random stimulus with occasional stalls.
    for (int i = 0; i < 40000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[3:0] != 4'd0, r[8]);
    end
    // R7: observed rates against the table.
    for (int o = 0; o < 2; o++) begin
      for (int a = 0; a < 5; a++) begin
        int n;
        n = 0;
        for (int b = 0; b < 5; b++) n += cnt[o][a][b];
        if (n >= 300) begin
          for (int b = 0; b < 5; b++) begin
            int exp, dif;
            exp = n * prob16(o, a - 2, b - 2) / 16;
            dif = cnt[o][a][b] - exp;
            if (dif < 0) dif = -dif;
            check(dif <= n / 12 + 10, "R7 rate", cnt[o][a][b], exp);
          end
        end
      end
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule